// File: doc/BRIEF.md
# Pipelined Floating-Point Multiplier Core

This block multiplies two numbers held in a custom floating-point format. The exponent width and the mantissa width are parameters. Each operand is packed as `{sign, exponent, mantissa}`. The mantissa carries its leading digit explicitly in its top bit, so an upstream unpack stage has already inserted that digit. The core forms the result sign, a rebiased exponent and the full mantissa product. It then uses the top bit of the product both to adjust the exponent and to choose which slice of the product becomes the output mantissa.

The result is not rounded. A downstream round-and-normalize stage consumes the result, the flag showing that discarded product bits were non-zero, and the exception flag. An exception flag enters with each operand pair and travels with it through the pipeline. The core sets the flag itself when the rebiased exponent leaves the representable range. Infinities and NaNs are not recognised. An operand whose leading digit is 0 is treated as zero.

Top module: `fpm_core`

## Requirements
- R1: Each cycle with `valid_i` high produces exactly one `done_o` pulse, three clock edges later: `valid_i` sampled at edge k gives `done_o` high after edge k+2. Back-to-back inputs give back-to-back pulses.
- R2: For non-zero operands, the result sign (bit `1+EXP_W+MAN_W-1`) is the XOR of the two operand signs.
- R3: Let P = man_a * man_b be the 2*MAN_W-bit product and msb = P[2*MAN_W-1]. The result mantissa (low MAN_W bits) is P[2*MAN_W-1:MAN_W] when msb is 1 and P[2*MAN_W-2:MAN_W-1] when msb is 0.
- R4: Let t = e_a + e_b - (BIAS+1) + msb, with BIAS = 2^(EXP_W-1)-1. The result exponent field (bits `MAN_W +: EXP_W`) is the low EXP_W bits of t.
- R5: For non-zero operands, `exc_o` is set when t < 0 or t > 2^EXP_W-1.
- R6: `exc_i` accompanying an operand pair is reflected in `exc_o` together with that pair's `done_o`.
- R7: If the leading mantissa digit (mantissa top bit) of either operand is 0, the whole result word is zero, `sticky_o` is 0, and `exc_o` equals the incoming `exc_i` alone.
- R8: `sticky_o` is the OR of the product bits below the selected mantissa slice, for non-zero operands.
- R9: Between `done_o` pulses, `res_o`, `exc_o` and `sticky_o` hold their last values.
- R10: During and right after reset, `done_o`, `res_o`, `exc_o` and `sticky_o` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operand pair present this cycle |
| exc_i | input | 1 | Exception already raised on this operand pair |
| op_a_i | input | 1+EXP_W+MAN_W | First operand {sign, exponent, mantissa with explicit leading digit} |
| op_b_i | input | 1+EXP_W+MAN_W | Second operand, same layout |
| res_o | output | 1+EXP_W+MAN_W | Product, same layout, unrounded |
| sticky_o | output | 1 | Discarded product bits were non-zero |
| exc_o | output | 1 | Exception for this result |
| done_o | output | 1 | Result valid this cycle |

## Verification
Two sources can raise `exc_o` in the same cycle: an incoming exception (R6) and an exponent range error (R5). A zero operand (R7) must override the range error while still passing the incoming exception through. Directed vectors combine extreme exponents with `exc_i` high and low, and with zero and non-zero leading digits. Random vectors mix all of these across continuous and gapped valid streams. The bench compares each `exc_o` against its reference, which is `exc_i` OR (range error AND NOT zero).

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  function automatic int unsigned fpm_bias(input int unsigned ew);
    return (32'd1 << (ew - 1)) - 32'd1;
  endfunction
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 7,
  localparam int unsigned W  = 1 + EXP_W + MAN_W,
  localparam int unsigned XW = EXP_W + 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             exc_i,
  input  logic [W-1:0]     op_a_i,
  input  logic [W-1:0]     op_b_i,
  output logic             vld_o,
  output logic             exc_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic [XW-1:0]    exp_o,
  output logic [MAN_W-1:0] man_a_o,
  output logic [MAN_W-1:0] man_b_o
);
  localparam int unsigned   BIAS = fpm_pkg::fpm_bias(EXP_W);
  localparam logic [XW-1:0] OFS  = XW'(BIAS + 1);

  logic [EXP_W-1:0] ea, eb;
  logic [MAN_W-1:0] ma, mb;
  logic [XW-1:0]    exp_d;
  logic             zero_d, sign_d;

  assign ea = op_a_i[MAN_W +: EXP_W];
  assign eb = op_b_i[MAN_W +: EXP_W];
  assign ma = op_a_i[MAN_W-1:0];
  assign mb = op_b_i[MAN_W-1:0];

  always_comb begin
    sign_d = op_a_i[W-1] ^ op_b_i[W-1];
    zero_d = ~ma[MAN_W-1] | ~mb[MAN_W-1];
    // two spare bits: one for overflow, one for sign
    exp_d  = XW'(ea) + XW'(eb) - OFS;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o   <= 1'b0;
      exc_o   <= 1'b0;
      sign_o  <= 1'b0;
      zero_o  <= 1'b0;
      exp_o   <= '0;
      man_a_o <= '0;
      man_b_o <= '0;
    end else begin
      vld_o <= valid_i;
      if (valid_i) begin
        exc_o   <= exc_i;
        sign_o  <= sign_d;
        zero_o  <= zero_d;
        exp_o   <= exp_d;
        man_a_o <= ma;
        man_b_o <= mb;
      end
    end
  end
endmodule

// File: rtl/fpm_mant_mult.sv
module fpm_mant_mult #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 7,
  localparam int unsigned XW = EXP_W + 2,
  localparam int unsigned PW = 2 * MAN_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             exc_i,
  input  logic             sign_i,
  input  logic             zero_i,
  input  logic [XW-1:0]    exp_i,
  input  logic [MAN_W-1:0] man_a_i,
  input  logic [MAN_W-1:0] man_b_i,
  output logic             vld_o,
  output logic             exc_o,
  output logic             sign_o,
  output logic             zero_o,
  output logic [XW-1:0]    exp_o,
  output logic [PW-1:0]    prod_o
);
  logic [PW-1:0] prod_d;

  assign prod_d = PW'(man_a_i) * PW'(man_b_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      exc_o  <= 1'b0;
      sign_o <= 1'b0;
      zero_o <= 1'b0;
      exp_o  <= '0;
      prod_o <= '0;
    end else begin
      vld_o <= vld_i;
      if (vld_i) begin
        exc_o  <= exc_i;
        sign_o <= sign_i;
        zero_o <= zero_i;
        exp_o  <= exp_i;
        prod_o <= prod_d;
      end
    end
  end
endmodule

// File: rtl/fpm_norm_sel.sv
module fpm_norm_sel #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 7,
  localparam int unsigned W  = 1 + EXP_W + MAN_W,
  localparam int unsigned XW = EXP_W + 2,
  localparam int unsigned PW = 2 * MAN_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          vld_i,
  input  logic          exc_i,
  input  logic          sign_i,
  input  logic          zero_i,
  input  logic [XW-1:0] exp_i,
  input  logic [PW-1:0] prod_i,
  output logic [W-1:0]  res_o,
  output logic          sticky_o,
  output logic          exc_o,
  output logic          done_o
);
  logic             msb, neg, ovf, sticky_d;
  logic [XW-1:0]    t;
  logic [MAN_W-1:0] mant;
  logic [W-1:0]     res_d;
  logic             exc_d;

  always_comb begin
    msb = prod_i[PW-1];
    t   = exp_i + XW'(msb);
    neg = t[XW-1];
    ovf = ~t[XW-1] & t[XW-2];
    if (msb) begin
      mant     = prod_i[PW-1 -: MAN_W];
      sticky_d = |prod_i[MAN_W-1:0];
    end else begin
      mant     = prod_i[PW-2 -: MAN_W];
      sticky_d = |prod_i[MAN_W-2:0];
    end
    if (zero_i) begin
      res_d    = '0;
      sticky_d = 1'b0;
      exc_d    = exc_i;
    end else begin
      res_d = {sign_i, t[EXP_W-1:0], mant};
      exc_d = exc_i | neg | ovf;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o    <= '0;
      sticky_o <= 1'b0;
      exc_o    <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      done_o <= vld_i;
      if (vld_i) begin
        res_o    <= res_d;
        sticky_o <= sticky_d;
        exc_o    <= exc_d;
      end
    end
  end
endmodule

// File: rtl/fpm_core.sv
module fpm_core #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 7,
  localparam int unsigned W  = 1 + EXP_W + MAN_W,
  localparam int unsigned XW = EXP_W + 2,
  localparam int unsigned PW = 2 * MAN_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic         exc_i,
  input  logic [W-1:0] op_a_i,
  input  logic [W-1:0] op_b_i,
  output logic [W-1:0] res_o,
  output logic         sticky_o,
  output logic         exc_o,
  output logic         done_o
);
  logic             s1_vld, s1_exc, s1_sign, s1_zero;
  logic [XW-1:0]    s1_exp;
  logic [MAN_W-1:0] s1_ma, s1_mb;
  logic             s2_vld, s2_exc, s2_sign, s2_zero;
  logic [XW-1:0]    s2_exp;
  logic [PW-1:0]    s2_prod;

  fpm_unpack #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_unpack (
    .clk_i, .rst_ni, .valid_i, .exc_i, .op_a_i, .op_b_i,
    .vld_o(s1_vld), .exc_o(s1_exc), .sign_o(s1_sign), .zero_o(s1_zero),
    .exp_o(s1_exp), .man_a_o(s1_ma), .man_b_o(s1_mb)
  );

  fpm_mant_mult #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_mult (
    .clk_i, .rst_ni,
    .vld_i(s1_vld), .exc_i(s1_exc), .sign_i(s1_sign), .zero_i(s1_zero),
    .exp_i(s1_exp), .man_a_i(s1_ma), .man_b_i(s1_mb),
    .vld_o(s2_vld), .exc_o(s2_exc), .sign_o(s2_sign), .zero_o(s2_zero),
    .exp_o(s2_exp), .prod_o(s2_prod)
  );

  fpm_norm_sel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_norm (
    .clk_i, .rst_ni,
    .vld_i(s2_vld), .exc_i(s2_exc), .sign_i(s2_sign), .zero_i(s2_zero),
    .exp_i(s2_exp), .prod_i(s2_prod),
    .res_o, .sticky_o, .exc_o, .done_o
  );
endmodule

// File: rtl/fpm_core_chk.sv
module fpm_core_chk #(
  parameter int unsigned EXP_W = 5,
  parameter int unsigned MAN_W = 7,
  localparam int unsigned W = 1 + EXP_W + MAN_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         exc_i,
  input logic [W-1:0] op_a_i,
  input logic [W-1:0] op_b_i,
  input logic [W-1:0] res_o,
  input logic         sticky_o,
  input logic         exc_o,
  input logic         done_o
);
  logic [1:0] age;
  logic       warm;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end
  assign warm = (age == 2'd3);

  // R1
  done_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (done_o == $past(valid_i, 3)));

  // R10
  cold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age == 2'd0) |-> (!done_o && res_o == '0 && !exc_o && !sticky_o));

  // R6
  exc_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && $past(exc_i, 3)) |-> exc_o);

  // R7
  zero_res_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && $past(!op_a_i[MAN_W-1] || !op_b_i[MAN_W-1], 3))
      |-> (res_o == '0 && !sticky_o && exc_o == $past(exc_i, 3)));

  // R2
  sign_xor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && $past(op_a_i[MAN_W-1] && op_b_i[MAN_W-1], 3))
      |-> (res_o[W-1] == $past(op_a_i[W-1] ^ op_b_i[W-1], 3)));

  // R3
  lead_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm && done_o && $past(op_a_i[MAN_W-1] && op_b_i[MAN_W-1], 3))
      |-> res_o[MAN_W-1]);

  // R9
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age != 2'd0 && !done_o) |-> ($stable(res_o) && $stable(exc_o) && $stable(sticky_o)));
endmodule

bind fpm_core fpm_core_chk #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .exc_i(exc_i),
  .op_a_i(op_a_i), .op_b_i(op_b_i), .res_o(res_o), .sticky_o(sticky_o),
  .exc_o(exc_o), .done_o(done_o)
);

// File: tb/fpm_core_tb.sv
module fpm_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int EXP_W = 5;
  localparam int MAN_W = 7;
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int BIAS  = (1 << (EXP_W - 1)) - 1;
  localparam int EMAX  = (1 << EXP_W) - 1;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         valid_i = 1'b0;
  logic         exc_i = 1'b0;
  logic [W-1:0] op_a_i = '0;
  logic [W-1:0] op_b_i = '0;
  logic [W-1:0] res_o;
  logic         sticky_o, exc_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [W+1:0] expq[$];
  logic [2:0]   vh = '0;
  logic [W+1:0] last = '0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  fpm_core #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_dut (
    .clk_i, .rst_ni, .valid_i, .exc_i, .op_a_i, .op_b_i,
    .res_o, .sticky_o, .exc_o, .done_o
  );

  // returns {sticky, exc, result}
  function automatic logic [W+1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic ex);
    int ea, eb, ma, mb, p, msb, t, mant;
    logic st, rng;
    logic [EXP_W-1:0] ef;
    ea = int'(a[MAN_W +: EXP_W]);
    eb = int'(b[MAN_W +: EXP_W]);
    ma = int'(a[MAN_W-1:0]);
    mb = int'(b[MAN_W-1:0]);
    if (ma < (1 << (MAN_W-1)) || mb < (1 << (MAN_W-1))) return {1'b0, ex, {W{1'b0}}};
    p   = ma * mb;
    msb = (p >> (2*MAN_W-1)) & 1;
    if (msb == 1) begin
      mant = (p >> MAN_W) & ((1 << MAN_W) - 1);
      st   = (p & ((1 << MAN_W) - 1)) != 0;
    end else begin
      mant = (p >> (MAN_W-1)) & ((1 << MAN_W) - 1);
      st   = (p & ((1 << (MAN_W-1)) - 1)) != 0;
    end
    t   = ea + eb - (BIAS + 1) + msb;
    rng = (t < 0) || (t > EMAX);
    ef  = t[EXP_W-1:0];
    return {st, ex | rng, a[W-1] ^ b[W-1], ef, mant[MAN_W-1:0]};
  endfunction

  function automatic logic [W-1:0] mk(input logic s, input int e, input int m);
    logic [EXP_W-1:0] ef;
    logic [MAN_W-1:0] mf;
    ef = e[EXP_W-1:0];
    mf = m[MAN_W-1:0];
    return {s, ef, mf};
  endfunction

  task automatic check_out();
    logic [W+1:0] got, want;
    got = {sticky_o, exc_o, res_o};
    n_chk++;
    if (done_o !== vh[2]) begin
      n_bad++;
      $display("FAIL R1 done_o=%0b expected %0b", done_o, vh[2]);
    end
    if (done_o === 1'b1) begin
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R1 done_o=1 expected 0 (no pending input)");
      end else begin
        want = expq.pop_front();
        n_chk++;
        if (got !== want) begin
          n_bad++;
          $display("FAIL R2-R8 {sticky,exc,res}=%h expected %h", got, want);
        end
      end
    end else begin
      n_chk++;
      if (got !== last) begin
        n_bad++;
        $display("FAIL R9 held outputs=%h expected %h", got, last);
      end
    end
    last = got;
  endtask

  task automatic step(input logic v, input logic ex, input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk_i);
    check_out();
    valid_i = v;
    exc_i   = ex;
    op_a_i  = a;
    op_b_i  = b;
    vh      = {vh[1:0], v};
    if (v) expq.push_back(ref_mul(a, b, ex));
  endtask

  task automatic drain();
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, '0, '0);
  endtask

  initial begin
    logic [W-1:0] a, b;
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk_i);
    // R10 reset state
    n_chk++;
    if ({done_o, exc_o, sticky_o, res_o} !== '0) begin
      n_bad++;
      $display("FAIL R10 outputs=%h expected 0", {done_o, exc_o, sticky_o, res_o});
    end
    rst_ni = 1'b1;
    // R10 right after release
    step(1'b0, 1'b0, '0, '0);

    // R3 R4 R2: 1.0 x 1.0 style, msb=0
    step(1'b1, 1'b0, mk(0, 15, 64), mk(1, 15, 64));
    // R3 R8: msb=1 with discarded bits
    step(1'b1, 1'b0, mk(1, 16, 127), mk(1, 14, 125));
    // R5 overflow, R6 off
    step(1'b1, 1'b0, mk(0, EMAX, 127), mk(0, EMAX, 127));
    // R5 underflow
    step(1'b1, 1'b0, mk(0, 0, 64), mk(0, 0, 64));
    // R5 + R6 together
    step(1'b1, 1'b1, mk(1, EMAX, 100), mk(0, 30, 90));
    // R7 zero overrides range error, exc_i low and high
    step(1'b1, 1'b0, mk(1, EMAX, 0), mk(0, EMAX, 127));
    step(1'b1, 1'b1, mk(0, 0, 127), mk(1, 0, 63));
    // R4 edge: exactly EMAX and exactly 0
    step(1'b1, 1'b0, mk(0, EMAX, 64), mk(0, BIAS + 1, 64));
    step(1'b1, 1'b0, mk(0, BIAS + 1, 64), mk(0, 0, 64));
    drain();

    // random, continuous and gapped
    for (int i = 0; i < 3000; i++) begin
      a = W'($urandom());
      b = W'($urandom());
      if (($urandom() & 7) != 0) a[MAN_W-1] = 1'b1;
      if (($urandom() & 7) != 0) b[MAN_W-1] = 1'b1;
      step((i < 1500) ? 1'b1 : 1'($urandom() & 1), 1'($urandom() % 5 == 0), a, b);
    end
    drain();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule